// File: doc/BRIEF.md
# Write-Once Memory Timing Divider

This block derives the timing strobe used by a nonvolatile memory controller from the system bus clock. Software configures it through one small register. The register holds a prescale select and a divisor, and it accepts only a single write after each reset. A read-only flag in the same register shows that this write has happened. The same flag decides whether the memory may be erased or programmed.

When the prescale bit is set, the bus clock is first divided by a fixed ratio (8 by default). The result is then divided by the divisor field plus one. The output is a one-bus-cycle enable strobe that stays in the bus clock domain. The controller counts these strobes to time its program and erase pulses. The intended strobe rate is between 150 kHz and 200 kHz. A range flag compares the configured ratio against the bus frequency given as a parameter and marks configurations that fall outside that window.

Top module: `nvm_clkdiv`

## Requirements
- R1: After reset, `rd_data` reads 0 and `pe_allow` is 0.
- R2: The first write after reset sets the loaded flag (`rd_data[7]`). This happens whatever value is written, including 0 and values with bit 7 set.
- R3: On that first write, `rd_data[6]` (prescale select) and `rd_data[5:0]` (divisor) take the written bits 6:0. They are readable from the next cycle on.
- R4: Every later write before the next reset is ignored, and all of `rd_data` stays unchanged.
- R5: `pe_allow` is 0 while the loaded flag is 0, and 1 once the flag is 1.
- R6: No `tick` strobe is produced while the loaded flag is 0.
- R7: With prescale select 0, `tick` pulses once every (divisor + 1) bus cycles.
- R8: With prescale select 1, `tick` pulses once every 8 × (divisor + 1) bus cycles.
- R9: Once the flag is loaded, `freq_bad` is 1 exactly when BUS_HZ / ratio lies below MIN_HZ or above MAX_HZ. Before that, `freq_bad` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data; bit 7 is not stored |
| rd_data | output | 8 | {loaded, prescale select, divisor} |
| tick | output | 1 | One-cycle divided timing strobe |
| pe_allow | output | 1 | Erase/program permitted |
| freq_bad | output | 1 | Configured strobe rate outside the allowed window |

## Verification
The hardest behaviour to reach is the second write. Each configuration can be loaded only once, so showing that a later write is ignored, and measuring a different divisor, both need a fresh reset. The stimulus therefore resets before every configuration. It loads a random or corner value (ratio 1, ratio 512, values at the window edges). It then writes the bitwise complement and confirms that the readback, the strobe period and the range flag have not moved.

// File: rtl/nvm_clkdiv_pkg.sv
package nvm_clkdiv_pkg;

   typedef enum logic {PRE_BYPASS = 1'b0, PRE_ON = 1'b1} pre_mode_e;

   // total division ratio for a given setting
   function automatic longint unsigned total_ratio(input pre_mode_e mode,
                                                   input int unsigned divisor,
                                                   input int unsigned pre_ratio);
      longint unsigned r;
      r = longint'(divisor) + 1;
      if (mode == PRE_ON) r = r * pre_ratio;
      return r;
   endfunction

endpackage

// File: rtl/nvm_clkdiv_cfg.sv
module nvm_clkdiv_cfg #(
   parameter int DIV_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [DIV_W:0]   wr_bits,
   output logic             loaded,
   output logic             pre_sel,
   output logic [DIV_W-1:0] divisor
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         loaded  <= 1'b0;
         pre_sel <= 1'b0;
         divisor <= '0;
      end else if (wr_en && !loaded) begin
         loaded  <= 1'b1;
         pre_sel <= wr_bits[DIV_W];
         divisor <= wr_bits[DIV_W-1:0];
      end
   end
endmodule

// File: rtl/nvm_clkdiv_pre.sv
module nvm_clkdiv_pre #(
   parameter int PRE_RATIO = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic pre_sel,
   output logic stb
);
   generate
      if (PRE_RATIO == 1) begin : g_none
         assign stb = run;
      end else begin : g_cnt
         localparam int PW = $clog2(PRE_RATIO);
         localparam logic [PW-1:0] LAST = PW'(PRE_RATIO - 1);
         logic [PW-1:0] cnt;
         always_ff @(posedge clk) begin
            if (!rst_n || !run || !pre_sel) cnt <= '0;
            else if (cnt == LAST)           cnt <= '0;
            else                            cnt <= cnt + 1'b1;
         end
         assign stb = run && (!pre_sel || (cnt == LAST));
      end
   endgenerate
endmodule

// File: rtl/nvm_clkdiv_cnt.sv
module nvm_clkdiv_cnt #(
   parameter int DIV_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             step,
   input  logic [DIV_W-1:0] limit,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;
   logic             at_end;

   assign at_end = (cnt == limit);

   always_ff @(posedge clk) begin
      if (!rst_n || !run) cnt <= '0;
      else if (step)      cnt <= at_end ? '0 : cnt + 1'b1;
   end

   assign tick = run && step && at_end;
endmodule

// File: rtl/nvm_clkdiv_range.sv
module nvm_clkdiv_range
   import nvm_clkdiv_pkg::*;
#(
   parameter int DIV_W     = 6,
   parameter int PRE_RATIO = 8,
   parameter longint unsigned BUS_HZ = 64'd8_000_000,
   parameter longint unsigned MIN_HZ = 64'd150_000,
   parameter longint unsigned MAX_HZ = 64'd200_000
) (
   input  logic             loaded,
   input  logic             pre_sel,
   input  logic [DIV_W-1:0] divisor,
   output logic             bad
);
   longint unsigned ratio;
   always_comb begin
      ratio = total_ratio(pre_mode_e'(pre_sel), int'(divisor), PRE_RATIO);
      // f = BUS_HZ / ratio ; compare without division
      bad = loaded && ((BUS_HZ < MIN_HZ * ratio) || (BUS_HZ > MAX_HZ * ratio));
   end
endmodule

// File: rtl/nvm_clkdiv.sv
module nvm_clkdiv #(
   parameter int DIV_W     = 6,
   parameter int PRE_RATIO = 8,
   parameter longint unsigned BUS_HZ = 64'd8_000_000,
   parameter longint unsigned MIN_HZ = 64'd150_000,
   parameter longint unsigned MAX_HZ = 64'd200_000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [DIV_W+1:0] wr_data,
   output logic [DIV_W+1:0] rd_data,
   output logic             tick,
   output logic             pe_allow,
   output logic             freq_bad
);
   localparam int CFG_W = DIV_W + 1;

   generate
      if (DIV_W < 1 || DIV_W > 16) begin : g_bad_w
         $error("nvm_clkdiv: DIV_W out of range");
      end
      if (PRE_RATIO < 1) begin : g_bad_pre
         $error("nvm_clkdiv: PRE_RATIO must be positive");
      end
      if (MIN_HZ > MAX_HZ) begin : g_bad_win
         $error("nvm_clkdiv: MIN_HZ above MAX_HZ");
      end
   endgenerate

   logic             loaded;
   logic             pre_sel;
   logic [DIV_W-1:0] divisor;
   logic             pre_stb;

   nvm_clkdiv_cfg #(.DIV_W(DIV_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
      .wr_bits(wr_data[CFG_W-1:0]),
      .loaded(loaded), .pre_sel(pre_sel), .divisor(divisor)
   );

   nvm_clkdiv_pre #(.PRE_RATIO(PRE_RATIO)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(loaded), .pre_sel(pre_sel), .stb(pre_stb)
   );

   nvm_clkdiv_cnt #(.DIV_W(DIV_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .run(loaded), .step(pre_stb),
      .limit(divisor), .tick(tick)
   );

   nvm_clkdiv_range #(
      .DIV_W(DIV_W), .PRE_RATIO(PRE_RATIO),
      .BUS_HZ(BUS_HZ), .MIN_HZ(MIN_HZ), .MAX_HZ(MAX_HZ)
   ) u_rng (
      .loaded(loaded), .pre_sel(pre_sel), .divisor(divisor), .bad(freq_bad)
   );

   assign rd_data  = {loaded, pre_sel, divisor};
   assign pe_allow = loaded;
endmodule

// File: rtl/nvm_clkdiv_chk.sv
module nvm_clkdiv_chk #(
   parameter int DIV_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [DIV_W+1:0] wr_data,
   input logic [DIV_W+1:0] rd_data,
   input logic             tick,
   input logic             pe_allow,
   input logic             freq_bad
);
   localparam int TOP = DIV_W + 1;

   assert_first_write_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !rd_data[TOP]) |=> rd_data[TOP]);

   assert_first_write_fields_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !rd_data[TOP]) |=> (rd_data[TOP-1:0] == $past(wr_data[TOP-1:0])));

   assert_later_write_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[TOP] |=> $stable(rd_data));

   assert_no_tick_unloaded_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !pe_allow |-> !tick);

   assert_range_only_loaded_R9: assert property (@(posedge clk) disable iff (!rst_n)
      freq_bad |-> pe_allow);

   assert_permit_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pe_allow |=> pe_allow);
endmodule

bind nvm_clkdiv nvm_clkdiv_chk #(.DIV_W(DIV_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
   .rd_data(rd_data), .tick(tick), .pe_allow(pe_allow), .freq_bad(freq_bad)
);

// File: tb/sim_nvm_clkdiv.sv
module sim_nvm_clkdiv;
   localparam int CLK_PERIOD = 10;
   localparam longint BUS = 8_000_000;
   localparam int WATCHDOG = 190_000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       tick, pe_allow, freq_bad;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done = 0;

   nvm_clkdiv u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .tick(tick), .pe_allow(pe_allow), .freq_bad(freq_bad)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > WATCHDOG && !done) begin
         errors = errors + 1;
         $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   function automatic int exp_ratio(input logic [7:0] d);
      return (d[6] ? 8 : 1) * (int'(d[5:0]) + 1);
   endfunction

   function automatic logic exp_bad(input logic [7:0] d);
      longint r = exp_ratio(d);
      return (BUS < 150_000 * r) || (BUS > 200_000 * r);
   endfunction

   task automatic check(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; wr_en = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic write_reg(input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // cycles between two successive strobes
   task automatic measure(output int period);
      int guard = 0;
      period = -1;
      while (!tick && guard < 2000) begin @(negedge clk); guard++; end
      if (!tick) return;
      period = 0;
      do begin @(negedge clk); period++; end while (!tick && period < 2000);
   endtask

   task automatic run_cfg(input logic [7:0] d);
      int per;
      int seen;
      do_reset();
      check("R1 rd_data", rd_data, 0);
      check("R1 pe_allow", pe_allow, 0);
      seen = 0;
      for (int i = 0; i < 12; i++) begin @(negedge clk); seen += tick; end
      check("R6 no tick unloaded", seen, 0);
      check("R5 pe_allow unloaded", pe_allow, 0);
      check("R9 freq_bad unloaded", freq_bad, 0);
      write_reg(d);
      check("R2 loaded", rd_data[7], 1);
      check("R3 fields", rd_data[6:0], d[6:0]);
      check("R5 pe_allow loaded", pe_allow, 1);
      check("R9 freq_bad", freq_bad, exp_bad(d));
      measure(per);
      check(d[6] ? "R8 prescaled period" : "R7 period", per, exp_ratio(d));
      write_reg(~d);
      check("R4 second write ignored", rd_data, {1'b1, d[6:0]});
      measure(per);
      check("R4 period after second write", per, exp_ratio(d));
      check("R4 freq_bad after second write", freq_bad, exp_bad(d));
   endtask

   initial begin
      void'($urandom(32'h5eed_0011));
      // directed corners
      run_cfg(8'h00);   // ratio 1, zero data still loads
      run_cfg(8'h80);   // bit 7 written high, not stored
      run_cfg(8'h7F);   // ratio 512, rate below window
      run_cfg(8'h27);   // ratio 40, exactly 200 kHz
      run_cfg(8'h26);   // ratio 39, just above window
      run_cfg(8'h34);   // ratio 53, inside window
      run_cfg(8'h35);   // ratio 54, just below window
      run_cfg(8'h44);   // prescaled ratio 40
      run_cfg(8'h46);   // prescaled ratio 56, below window
      for (int k = 0; k < 20; k++) run_cfg(8'($urandom));
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule